// File: doc/BRIEF.md
# Strided Chunk Gather Reader

This block fetches a block of words from a memory-mapped RAM and plays them out as a framed stream. The block is made of `NUM_CHUNKS` runs of `CHUNK_LEN` consecutive words. The runs begin `STRIDE` addresses apart, starting from a base address that is captured with a one-cycle start pulse. The RAM answers a read one cycle after the read enable. The stream therefore carries the RAM data directly, with valid, start-of-packet and end-of-packet markers delayed to match.

Several interleaved blocks can be fetched one after another by pulsing start with bases 0, `CHUNK_LEN`, 2·`CHUNK_LEN` and so on. There are `STRIDE/CHUNK_LEN` such blocks, and together they cover the region without gaps. `STRIDE` must be at least `CHUNK_LEN`.

The controller has three states:
- `ST_IDLE` waits for start.
- `ST_READ` issues one read per cycle.
- `ST_DRAIN` waits for the last word to leave the read pipeline.

It has three transitions:
- `ST_IDLE`→`ST_READ` on an accepted start.
- `ST_READ`→`ST_DRAIN` when the read of the final address is issued.
- `ST_DRAIN`→`ST_IDLE` when the end-of-packet word appears, which is the cycle in which done pulses.

Top module: `strided_block_reader`

## Requirements
- R1: After reset, and after a reset applied in the middle of a transfer, the read enable, stream valid and done outputs are all low.
- R2: A start pulse in the idle state captures `start_addr_i`. The transfer then reads exactly `CHUNK_LEN*NUM_CHUNKS` words. Chunk k covers addresses base + k·STRIDE up to base + k·STRIDE + CHUNK_LEN − 1, modulo 2^ADDR_W.
- R3: Stream words appear in strictly increasing order within a chunk, and chunks appear in increasing order. The last word comes from base + (NUM_CHUNKS−1)·STRIDE + CHUNK_LEN − 1, and no address beyond it is read.
- R4: The read enable rises in the cycle after the accepted start. Stream valid equals the read enable delayed by one cycle.
- R5: The start-of-packet marker is high only on the first word, and the end-of-packet marker is high only on the last word.
- R6: Done is a single-cycle pulse, high in the cycle that outputs the final word. In the next cycle the read enable, valid and done are low.
- R7: A start pulse that arrives while a transfer is in progress is ignored, including one that arrives in the done cycle. The words of the running transfer are unchanged, and no new read follows.
- R8: Between consecutive read cycles, the read address rises by 1 inside a chunk and by STRIDE − CHUNK_LEN + 1 at a chunk boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | One-cycle start pulse |
| start_addr_i | input | ADDR_W | Base address, captured with start |
| mem_rd_en_o | output | 1 | RAM read enable |
| mem_rd_addr_o | output | ADDR_W | RAM read address |
| mem_rd_data_i | input | DATA_W | RAM read data, one cycle after enable |
| st_valid_o | output | 1 | Stream word valid |
| st_data_o | output | DATA_W | Stream word |
| st_sop_o | output | 1 | First word of the block |
| st_eop_o | output | 1 | Last word of the block |
| done_o | output | 1 | Transfer complete pulse |

## Verification
Two functions can meet in one cycle: the done pulse that closes a transfer, and the arrival of a new start pulse. The bench drives start in exactly the cycle in which done is seen, and also drives it in the middle of the read phase. In both cases it judges the outcome at the ports: the word sequence must be unchanged, and no further read enable or valid may appear in the cycles that follow. A base near the top of the address space forces the chunk addresses to wrap past zero.

// File: rtl/srd_pkg.sv
package srd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_DRAIN = 2'd2
    } srd_state_e;
endpackage

// File: rtl/srd_addr_gen.sv
module srd_addr_gen #(
    parameter int ADDR_W     = 8,
    parameter int CHUNK_LEN  = 2,
    parameter int STRIDE     = 4,
    parameter int NUM_CHUNKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              is_first,
    output logic              is_last
);
    localparam int WIDX_W = $clog2(CHUNK_LEN + 1);
    localparam int CIDX_W = $clog2(NUM_CHUNKS + 1);
    localparam logic [WIDX_W-1:0] W_LAST = WIDX_W'(CHUNK_LEN - 1);
    localparam logic [CIDX_W-1:0] C_LAST = CIDX_W'(NUM_CHUNKS - 1);

    logic [ADDR_W-1:0] chunk_base_q;
    logic [WIDX_W-1:0] widx_q;
    logic [CIDX_W-1:0] cidx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chunk_base_q <= '0;
            widx_q       <= '0;
            cidx_q       <= '0;
        end else if (load) begin
            chunk_base_q <= base;
            widx_q       <= '0;
            cidx_q       <= '0;
        end else if (adv) begin
            if (widx_q == W_LAST) begin
                widx_q       <= '0;
                chunk_base_q <= chunk_base_q + ADDR_W'(STRIDE);
                cidx_q       <= cidx_q + 1'b1;
            end else begin
                widx_q <= widx_q + 1'b1;
            end
        end
    end

    assign addr     = chunk_base_q + ADDR_W'(widx_q);
    assign is_first = (widx_q == '0) && (cidx_q == '0);
    assign is_last  = (widx_q == W_LAST) && (cidx_q == C_LAST);
endmodule

// File: rtl/srd_lat_pipe.sv
module srd_lat_pipe #(
    parameter int RD_LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_in,
    input  logic sop_in,
    input  logic eop_in,
    output logic vld_out,
    output logic sop_out,
    output logic eop_out
);
    logic [2:0] stage_q [RD_LAT];

    generate
        for (genvar g = 0; g < RD_LAT; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (g == 0) begin
                    stage_q[g] <= {vld_in, sop_in, eop_in};
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign vld_out = stage_q[RD_LAT-1][2];
    assign sop_out = stage_q[RD_LAT-1][1];
    assign eop_out = stage_q[RD_LAT-1][0];
endmodule

// File: rtl/strided_block_reader.sv
module strided_block_reader
    import srd_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int CHUNK_LEN  = 2,
    parameter int STRIDE     = 4,
    parameter int NUM_CHUNKS = 3,
    parameter int RD_LAT     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    input  logic [DATA_W-1:0] mem_rd_data_i,
    output logic              st_valid_o,
    output logic [DATA_W-1:0] st_data_o,
    output logic              st_sop_o,
    output logic              st_eop_o,
    output logic              done_o
);
    srd_state_e state_q, state_d;
    logic load, rd_en, is_first, is_last;
    logic pipe_vld, pipe_sop, pipe_eop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        rd_en   = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    load    = 1'b1;
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                rd_en = 1'b1;
                if (is_last) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (pipe_vld && pipe_eop) begin
                    done_o  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    srd_addr_gen #(
        .ADDR_W(ADDR_W), .CHUNK_LEN(CHUNK_LEN),
        .STRIDE(STRIDE), .NUM_CHUNKS(NUM_CHUNKS)
    ) u_agen (
        .clk(clk), .rst_n(rst_n), .load(load), .base(start_addr_i),
        .adv(rd_en), .addr(mem_rd_addr_o),
        .is_first(is_first), .is_last(is_last)
    );

    srd_lat_pipe #(.RD_LAT(RD_LAT)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .vld_in(rd_en), .sop_in(rd_en && is_first), .eop_in(rd_en && is_last),
        .vld_out(pipe_vld), .sop_out(pipe_sop), .eop_out(pipe_eop)
    );

    assign mem_rd_en_o = rd_en;
    assign st_valid_o  = pipe_vld;
    assign st_sop_o    = pipe_sop;
    assign st_eop_o    = pipe_eop;
    assign st_data_o   = mem_rd_data_i;
endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
    parameter int ADDR_W     = 8,
    parameter int CHUNK_LEN  = 2,
    parameter int STRIDE     = 4,
    parameter int RD_LAT     = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_en_o,
    input logic [ADDR_W-1:0] mem_rd_addr_o,
    input logic              st_valid_o,
    input logic              st_sop_o,
    input logic              st_eop_o,
    input logic              done_o
);
    localparam logic [ADDR_W-1:0] JUMP = ADDR_W'(STRIDE - CHUNK_LEN + 1);

    // R6
    done_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (st_valid_o && st_eop_o));
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !st_valid_o && !mem_rd_en_o));
    // R5
    sop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_sop_o || st_eop_o) |-> st_valid_o);
    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en_o && $past(mem_rd_en_o)) |->
            ((mem_rd_addr_o == $past(mem_rd_addr_o) + ADDR_W'(1)) ||
             (mem_rd_addr_o == $past(mem_rd_addr_o) + JUMP)));

    generate
        if (RD_LAT == 1) begin : g_lat1
            // R4
            valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                mem_rd_en_o |=> st_valid_o);
            // R4
            no_valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !mem_rd_en_o |=> !st_valid_o);
        end
    endgenerate
endmodule

bind strided_block_reader srd_checker #(
    .ADDR_W(ADDR_W), .CHUNK_LEN(CHUNK_LEN), .STRIDE(STRIDE), .RD_LAT(RD_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd_en_o(mem_rd_en_o),
    .mem_rd_addr_o(mem_rd_addr_o), .st_valid_o(st_valid_o),
    .st_sop_o(st_sop_o), .st_eop_o(st_eop_o), .done_o(done_o)
);

// File: tb/sim_strided_block_reader.sv
module sim_strided_block_reader;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8, DATA_W = 16, CL = 2, ST = 4, NC = 3;
    localparam int NW = CL * NC;
    localparam int NV = 5;
    localparam int VB [NV] = '{0, 2, 100, 37, 250};
    localparam int VI [NV] = '{-1, -1, 3, 99, -1};
    localparam int VA [NV] = '{0, 0, 7, 55, 0};

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic mem_rd_en_o, st_valid_o, st_sop_o, st_eop_o, done_o;
    logic [ADDR_W-1:0] mem_rd_addr_o;
    logic [DATA_W-1:0] mem_rd_data_i, st_data_o;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // RAM model: word at address a holds 16'hA500 | a, one-cycle read latency
    always_ff @(posedge clk) begin
        if (mem_rd_en_o) mem_rd_data_i <= 16'hA500 | DATA_W'(mem_rd_addr_o);
    end

    strided_block_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHUNK_LEN(CL),
                           .STRIDE(ST), .NUM_CHUNKS(NC), .RD_LAT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .mem_rd_en_o(mem_rd_en_o), .mem_rd_addr_o(mem_rd_addr_o),
        .mem_rd_data_i(mem_rd_data_i), .st_valid_o(st_valid_o), .st_data_o(st_data_o),
        .st_sop_o(st_sop_o), .st_eop_o(st_eop_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input int base, input int inj, input int inj_addr);
        int got [32];
        int n = 0, sop_cnt = 0, sop_pos = -1, eop_cnt = 0, eop_pos = -1;
        int done_cnt = 0, done_pos = -1, first_cyc = -1, after_bad = 0;
        bit done_seen = 1'b0, rd0;
        @(negedge clk);
        start_i = 1'b1; start_addr_i = ADDR_W'(base);
        @(negedge clk);
        start_i = 1'b0;
        rd0 = mem_rd_en_o;
        for (int cyc = 0; cyc < 24; cyc++) begin
            if (done_seen && (st_valid_o || mem_rd_en_o || done_o)) after_bad++;
            if (st_valid_o) begin
                if (first_cyc < 0) first_cyc = cyc;
                if (n < 32) got[n] = int'(st_data_o);
                if (st_sop_o) begin sop_cnt++; sop_pos = n; end
                if (st_eop_o) begin eop_cnt++; eop_pos = n; end
                n++;
            end
            if (done_o) begin done_cnt++; done_pos = n - 1; end
            if (cyc == inj || (inj == 99 && done_o)) begin
                start_i = 1'b1; start_addr_i = ADDR_W'(inj_addr);
            end else begin
                start_i = 1'b0;
            end
            if (done_o) done_seen = 1'b1;
            @(negedge clk);
        end
        start_i = 1'b0;
        check(n == NW, "R2", "word count", n, NW);
        for (int i = 0; i < NW && i < n; i++) begin
            int exp_a = (base + (i / CL) * ST + (i % CL)) & 255;
            check(got[i] == (16'hA500 | exp_a), "R3", "word order", got[i], 16'hA500 | exp_a);
        end
        check(rd0 == 1'b1, "R4", "read enable after start", int'(rd0), 1);
        check(first_cyc == 1, "R4", "first valid cycle", first_cyc, 1);
        check(sop_cnt == 1 && sop_pos == 0, "R5", "sop position", sop_pos, 0);
        check(eop_cnt == 1 && eop_pos == NW-1, "R5", "eop position", eop_pos, NW-1);
        check(done_cnt == 1, "R6", "done pulses", done_cnt, 1);
        check(done_pos == NW-1, "R6", "done on last word", done_pos, NW-1);
        check(after_bad == 0, "R6", "activity after done", after_bad, 0);
        if (inj >= 0) check(after_bad == 0 && n == NW, "R7", "busy start ignored", after_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!mem_rd_en_o && !st_valid_o && !done_o, "R1", "reset outputs",
              int'({mem_rd_en_o, st_valid_o, done_o}), 0);
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++) run_vec(VB[v], VI[v], VA[v]);
        // R1: reset in the middle of a transfer
        @(negedge clk); start_i = 1'b1; start_addr_i = 8'd20;
        @(negedge clk); start_i = 1'b0;
        repeat (2) @(negedge clk);
        check(mem_rd_en_o == 1'b1, "R1", "busy before reset", int'(mem_rd_en_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!mem_rd_en_o && !st_valid_o && !done_o, "R1", "outputs after mid reset",
              int'({mem_rd_en_o, st_valid_o, done_o}), 0);
        rst_n = 1'b1;
        run_vec(12, -1, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule